// File: doc/BRIEF.md
# Banked Fault Address Register

This block holds the virtual address of the access that raised a synchronous data abort. It keeps two 32-bit copies, one for the secure world and one for the non-secure world. It also decides the outcome of each coprocessor-style read or write request aimed at the register.

A request is first matched against the register's encoding fields. The block then weighs several inputs:

- the current privilege level;
- which higher levels exist and their instruction width;
- the hypervisor trap controls;
- the secure-state bit.

From these, each matching request completes with data, is reported as undefined, or is sent to the hypervisor with syndrome class 0x03. A fault-capture strobe loads a new fault address into the copy for the current security state.

The secure copy also serves as the hypervisor's data fault address on systems that have levels 2 and 3 but lack the 64-bit feature. A separate alias port reads and writes it under that name.

Responses are registered and appear exactly one cycle after the request.

Top module: `fault_addr_bank`

## Requirements
- R1: After reset both copies read as zero and all response outputs are low.
- R2: A request answers only when coprocessor = 4'b1111, opc1 = 3'b000, CRn = 4'b0110, CRm = 4'b0000 and opc2 = 3'b000. Any other request gives no response pulse and changes no copy.
- R3: A matching request gives `rsp_undef` when the 32-bit level-1 feature is absent or the privilege level is 0. No copy changes.
- R4: At level 1 with level 2 present and enabled, a set CRn-6 trap bit gives `rsp_trap` with `rsp_ec` = 6'h03, whatever the other trap bits are. `rsp_trap_aa64` is the inverse of `l2_aa32`. With level 2 not enabled, no trap is raised.
- R5: At level 1, if the CRn-6 bit does not trap, reads are trapped by the read-VM bit only and writes by the write-VM bit only. A trapped access changes no copy.
- R6: Accepted accesses at levels 1 and 2 always use the non-secure copy. This copy doubles as the single unbanked copy when level 3 is absent or 64-bit.
- R7: At level 3, `sec_ns` = 0 selects the secure copy and `sec_ns` = 1 selects the non-secure copy.
- R8: When levels 2 and 3 are present and the 64-bit feature is absent, `alias_rd_data` shows the secure copy and `alias_wr_en` writes it. Otherwise `alias_rd_data` is zero and alias writes are ignored.
- R9: `cap_valid` loads `cap_addr` into the secure copy when level 3 is 32-bit and `sec_ns` = 0, and into the non-secure copy otherwise. On the same copy in the same cycle, a capture beats a software write, which in turn beats an alias write.
- R10: `rsp_done`, `rsp_undef` and `rsp_trap` are one-cycle pulses one cycle after the request. At most one of them is high. Read data is the copy's value before any same-cycle update, and it is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| feat_l1_aa32 | input | 1 | 32-bit level-1 feature present |
| l2_present | input | 1 | Level 2 implemented |
| l2_enabled | input | 1 | Level 2 enabled for current state |
| l2_aa32 | input | 1 | Level 2 runs 32-bit |
| l3_present | input | 1 | Level 3 implemented |
| l3_aa32 | input | 1 | Level 3 runs 32-bit |
| feat_aa64 | input | 1 | 64-bit feature present |
| hyp_trap_crn6 | input | 1 | Trap level-1 accesses to CRn 6 registers |
| hyp_trap_rd_vm | input | 1 | Trap level-1 reads of VM registers |
| hyp_trap_wr_vm | input | 1 | Trap level-1 writes of VM registers |
| sec_ns | input | 1 | Non-secure state bit |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor field |
| req_opc1 | input | 3 | opc1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_opc2 | input | 3 | opc2 field |
| req_wdata | input | 32 | Write data |
| cap_valid | input | 1 | Fault capture strobe |
| cap_addr | input | 32 | Faulting virtual address |
| alias_wr_en | input | 1 | Write through hypervisor alias name |
| alias_wr_data | input | 32 | Alias write data |
| rsp_done | output | 1 | Access accepted (pulse) |
| rsp_rdata | output | 32 | Read data |
| rsp_undef | output | 1 | Undefined-instruction pulse |
| rsp_trap | output | 1 | Trap-to-hypervisor pulse |
| rsp_trap_aa64 | output | 1 | Trap is taken to a 64-bit level 2 |
| rsp_ec | output | 6 | Syndrome class of the trap |
| alias_rd_data | output | 32 | Secure copy under the alias name |

## Verification
The bench targets the read/write asymmetry of the VM trap bits. A design that checked one bit for both directions would trap the wrong access, or let a trapped write change a copy. It sets several trap bits together to confirm that the CRn-6 check wins, and that traps disappear when level 2 is disabled. It collides a capture with a software write on one copy, so a design with the wrong priority would keep the software value. It reads in the same cycle as a capture, so a design that forwarded the new value would return it instead of the old one. It toggles the alias condition to catch a design that lets alias writes land when the alias does not exist.

// File: rtl/fab_pkg.sv
// Package: shared constants and types for the banked fault address register.
// Assumes a two-copy bank; slot 0 is secure, slot 1 is non-secure.
package fab_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned EC_W   = 6;
    localparam int unsigned NSLOT  = 2;

    localparam logic SLOT_SEC = 1'b0;
    localparam logic SLOT_NSC = 1'b1;

    localparam logic [EC_W-1:0] EC_CP15_TRAP = 6'h03;

    localparam logic [3:0] ENC_CP   = 4'b1111;
    localparam logic [2:0] ENC_OPC1 = 3'b000;
    localparam logic [3:0] ENC_CRN  = 4'b0110;
    localparam logic [3:0] ENC_CRM  = 4'b0000;
    localparam logic [2:0] ENC_OPC2 = 3'b000;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_OK    = 2'd1,
        ACC_UNDEF = 2'd2,
        ACC_TRAP  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/fab_access_check.sv
// Module: fab_access_check
// Combinational decision for one request: not-for-us, accept, undefined or
// trap, plus the copy an accepted access uses. Assumes cur_lvl is the level
// issuing the request and that trap bits are only meaningful with level 2.
module fab_access_check
    import fab_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [3:0] req_cp,
    input  logic [2:0] req_opc1,
    input  logic [3:0] req_crn,
    input  logic [3:0] req_crm,
    input  logic [2:0] req_opc2,
    input  logic [1:0] cur_lvl,
    input  logic       feat_l1_aa32,
    input  logic       l2_present,
    input  logic       l2_enabled,
    input  logic       hyp_trap_crn6,
    input  logic       hyp_trap_rd_vm,
    input  logic       hyp_trap_wr_vm,
    input  logic       sec_ns,
    output acc_kind_e  kind,
    output logic       slot
);
    logic enc_hit;
    logic hyp_on;
    logic vm_trap;

    // Purpose: match the request against this register's encoding.
    always_comb begin
        enc_hit = (req_cp == ENC_CP) && (req_opc1 == ENC_OPC1) &&
                  (req_crn == ENC_CRN) && (req_crm == ENC_CRM) &&
                  (req_opc2 == ENC_OPC2);
    end

    // Purpose: pick the VM trap bit that applies to this access direction.
    always_comb begin
        hyp_on  = l2_present && l2_enabled;
        vm_trap = req_write ? hyp_trap_wr_vm : hyp_trap_rd_vm;
    end

    // Purpose: prioritised outcome and copy selection.
    always_comb begin
        kind = ACC_NONE;
        slot = SLOT_NSC;
        if (req_valid && enc_hit) begin
            if (!feat_l1_aa32 || cur_lvl == 2'd0) begin
                kind = ACC_UNDEF;
            end else if (cur_lvl == 2'd1) begin
                if (hyp_on && hyp_trap_crn6)  kind = ACC_TRAP;
                else if (hyp_on && vm_trap)   kind = ACC_TRAP;
                else                          kind = ACC_OK;
            end else if (cur_lvl == 2'd2) begin
                kind = ACC_OK;
            end else begin
                kind = ACC_OK;
                slot = sec_ns ? SLOT_NSC : SLOT_SEC;
            end
        end
    end
endmodule

// File: rtl/fab_copy_store.sv
// Module: fab_copy_store
// The register copies. Each slot takes, in priority order, a fault capture,
// a software write, then (secure slot only) an alias write. Assumes the
// caller qualifies every write enable.
module fab_copy_store
    import fab_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NS = NSLOT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_we,
    input  logic                 cap_slot,
    input  logic [AW-1:0]        cap_data,
    input  logic                 sw_we,
    input  logic                 sw_slot,
    input  logic [AW-1:0]        sw_data,
    input  logic                 al_we,
    input  logic [AW-1:0]        al_data,
    output logic [NS-1:0][AW-1:0] slot_q
);
    for (genvar i = 0; i < NS; i++) begin : g_slot
        localparam logic MY_ID = 1'(i);
        localparam bit   ALIASED = (MY_ID == SLOT_SEC);

        // Purpose: update one copy with capture > software > alias priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (cap_we && cap_slot == MY_ID) begin
                slot_q[i] <= cap_data;
            end else if (sw_we && sw_slot == MY_ID) begin
                slot_q[i] <= sw_data;
            end else if (ALIASED && al_we) begin
                slot_q[i] <= al_data;
            end
        end

        // R9
        cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_we && cap_slot == MY_ID) |=> (slot_q[i] == $past(cap_data)));
    end
endmodule

// File: rtl/fault_addr_bank.sv
// Module: fault_addr_bank (top)
// Banked fault address register with access checking. Responses are
// registered one cycle after a request. Assumes at most one request per
// cycle and that configuration inputs are stable around a request.
module fault_addr_bank
    import fab_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cur_lvl,
    input  logic        feat_l1_aa32,
    input  logic        l2_present,
    input  logic        l2_enabled,
    input  logic        l2_aa32,
    input  logic        l3_present,
    input  logic        l3_aa32,
    input  logic        feat_aa64,
    input  logic        hyp_trap_crn6,
    input  logic        hyp_trap_rd_vm,
    input  logic        hyp_trap_wr_vm,
    input  logic        sec_ns,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [3:0]  req_cp,
    input  logic [2:0]  req_opc1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_opc2,
    input  logic [31:0] req_wdata,
    input  logic        cap_valid,
    input  logic [31:0] cap_addr,
    input  logic        alias_wr_en,
    input  logic [31:0] alias_wr_data,
    output logic        rsp_done,
    output logic [31:0] rsp_rdata,
    output logic        rsp_undef,
    output logic        rsp_trap,
    output logic        rsp_trap_aa64,
    output logic [5:0]  rsp_ec,
    output logic [31:0] alias_rd_data
);
    acc_kind_e                     kind;
    logic                          acc_slot;
    logic                          cap_slot;
    logic                          alias_on;
    logic                          sw_we;
    logic [NSLOT-1:0][ADDR_W-1:0]  slot_q;

    fab_access_check i_check (
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_cp         (req_cp),
        .req_opc1       (req_opc1),
        .req_crn        (req_crn),
        .req_crm        (req_crm),
        .req_opc2       (req_opc2),
        .cur_lvl        (cur_lvl),
        .feat_l1_aa32   (feat_l1_aa32),
        .l2_present     (l2_present),
        .l2_enabled     (l2_enabled),
        .hyp_trap_crn6  (hyp_trap_crn6),
        .hyp_trap_rd_vm (hyp_trap_rd_vm),
        .hyp_trap_wr_vm (hyp_trap_wr_vm),
        .sec_ns         (sec_ns),
        .kind           (kind),
        .slot           (acc_slot)
    );

    // Purpose: derive capture target, alias condition and software write.
    always_comb begin
        cap_slot = (l3_present && l3_aa32 && !sec_ns) ? SLOT_SEC : SLOT_NSC;
        alias_on = l2_present && l3_present && !feat_aa64;
        sw_we    = (kind == ACC_OK) && req_write;
    end

    fab_copy_store #(.AW(ADDR_W), .NS(NSLOT)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_we   (cap_valid),
        .cap_slot (cap_slot),
        .cap_data (cap_addr),
        .sw_we    (sw_we),
        .sw_slot  (acc_slot),
        .sw_data  (req_wdata),
        .al_we    (alias_wr_en && alias_on),
        .al_data  (alias_wr_data),
        .slot_q   (slot_q)
    );

    // Purpose: expose the secure copy under the hypervisor alias name.
    always_comb begin
        alias_rd_data = alias_on ? slot_q[SLOT_SEC] : '0;
    end

    // Purpose: register the one-cycle response for the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done      <= 1'b0;
            rsp_rdata     <= '0;
            rsp_undef     <= 1'b0;
            rsp_trap      <= 1'b0;
            rsp_trap_aa64 <= 1'b0;
            rsp_ec        <= '0;
        end else begin
            rsp_done      <= (kind == ACC_OK);
            rsp_rdata     <= (kind == ACC_OK && !req_write) ? slot_q[acc_slot] : '0;
            rsp_undef     <= (kind == ACC_UNDEF);
            rsp_trap      <= (kind == ACC_TRAP);
            rsp_trap_aa64 <= (kind == ACC_TRAP) && !l2_aa32;
            rsp_ec        <= (kind == ACC_TRAP) ? EC_CP15_TRAP : '0;
        end
    end

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_done, rsp_undef, rsp_trap}));

    // R4
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_ec == 6'h03));

    // R3
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_NONE && cur_lvl == 2'd0) |=> rsp_undef);

    // R5
    reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == ACC_UNDEF || kind == ACC_TRAP) && !cap_valid && !alias_wr_en)
            |=> $stable(slot_q));

    // R10
    pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !req_valid) |=> !rsp_done);
endmodule

// File: tb/test_fault_addr_bank.sv
// Directed bench for fault_addr_bank; one task per scenario.
module test_fault_addr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_lvl = 2'd0;
    logic        feat_l1_aa32 = 1'b1, l2_present = 1'b1, l2_enabled = 1'b1;
    logic        l2_aa32 = 1'b1, l3_present = 1'b1, l3_aa32 = 1'b1, feat_aa64 = 1'b0;
    logic        hyp_trap_crn6 = 1'b0, hyp_trap_rd_vm = 1'b0, hyp_trap_wr_vm = 1'b0;
    logic        sec_ns = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_cp = 4'b1111, req_crn = 4'b0110, req_crm = 4'b0000;
    logic [2:0]  req_opc1 = 3'b000, req_opc2 = 3'b000;
    logic [31:0] req_wdata = '0;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_addr = '0;
    logic        alias_wr_en = 1'b0;
    logic [31:0] alias_wr_data = '0;
    logic        rsp_done, rsp_undef, rsp_trap, rsp_trap_aa64;
    logic [31:0] rsp_rdata, alias_rd_data;
    logic [5:0]  rsp_ec;

    int tests = 0;
    int fails = 0;
    logic        o_done, o_undef, o_trap, o_aa64;
    logic [31:0] o_rdata;
    logic [5:0]  o_ec;

    always #10 clk = ~clk;

    fault_addr_bank i_fault_addr_bank (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request at a falling edge, capture outputs at the next one.
    task automatic access(input bit wr, input logic [1:0] lvl, input logic ns,
                          input logic [31:0] wd);
        @(negedge clk);
        cur_lvl = lvl; sec_ns = ns; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        o_done = rsp_done; o_undef = rsp_undef; o_trap = rsp_trap;
        o_aa64 = rsp_trap_aa64; o_rdata = rsp_rdata; o_ec = rsp_ec;
        req_valid = 1'b0; cap_valid = 1'b0; alias_wr_en = 1'b0;
    endtask

    task automatic expect_copy(input logic ns, input logic [31:0] exp, input string tag);
        access(1'b0, 2'd3, ns, '0);
        chk(o_done && o_rdata == exp, tag, o_rdata, exp);
    endtask

    task automatic t_reset;
        chk(!rsp_done && !rsp_undef && !rsp_trap && rsp_rdata == 0, "R1 outputs", rsp_rdata, 0);
        expect_copy(1'b0, 32'h0, "R1 secure copy");
        expect_copy(1'b1, 32'h0, "R1 nonsecure copy");
    endtask

    task automatic t_level3_bank;
        access(1'b1, 2'd3, 1'b0, 32'hAAAA_0001);
        chk(o_done && o_rdata == 0, "R10 write rdata", o_rdata, 0);
        access(1'b1, 2'd3, 1'b1, 32'hBBBB_0002);
        expect_copy(1'b0, 32'hAAAA_0001, "R7 secure");
        expect_copy(1'b1, 32'hBBBB_0002, "R7 nonsecure");
    endtask

    task automatic t_low_levels;
        access(1'b1, 2'd1, 1'b0, 32'hCCCC_0003);
        chk(o_done, "R6 lvl1 write accepted", {31'd0, o_done}, 1);
        expect_copy(1'b1, 32'hCCCC_0003, "R6 lvl1 hits nonsecure");
        expect_copy(1'b0, 32'hAAAA_0001, "R6 secure untouched");
        access(1'b0, 2'd2, 1'b0, '0);
        chk(o_done && o_rdata == 32'hCCCC_0003, "R6 lvl2 read", o_rdata, 32'hCCCC_0003);
    endtask

    task automatic t_undef;
        access(1'b1, 2'd0, 1'b1, 32'hDEAD_0000);
        chk(o_undef && !o_done, "R3 level0 undef", {31'd0, o_undef}, 1);
        feat_l1_aa32 = 1'b0;
        access(1'b1, 2'd1, 1'b1, 32'hDEAD_0001);
        chk(o_undef, "R3 feature absent undef", {31'd0, o_undef}, 1);
        feat_l1_aa32 = 1'b1;
        expect_copy(1'b1, 32'hCCCC_0003, "R3 copy unchanged");
    endtask

    task automatic t_crn6;
        hyp_trap_crn6 = 1'b1; hyp_trap_rd_vm = 1'b1; l2_aa32 = 1'b0;
        access(1'b1, 2'd1, 1'b1, 32'hDEAD_0002);
        chk(o_trap && o_ec == 6'h03, "R4 trap class", {26'd0, o_ec}, 32'h3);
        chk(o_aa64, "R4 trap to 64-bit", {31'd0, o_aa64}, 1);
        l2_aa32 = 1'b1;
        access(1'b0, 2'd1, 1'b1, '0);
        chk(o_trap && !o_aa64, "R4 trap to 32-bit", {31'd0, o_aa64}, 0);
        l2_enabled = 1'b0;
        access(1'b0, 2'd1, 1'b1, '0);
        chk(o_done && !o_trap, "R4 disabled level2 no trap", {31'd0, o_trap}, 0);
        l2_enabled = 1'b1; hyp_trap_crn6 = 1'b0; hyp_trap_rd_vm = 1'b0;
        expect_copy(1'b1, 32'hCCCC_0003, "R4 copy unchanged");
    endtask

    task automatic t_vm;
        hyp_trap_rd_vm = 1'b1;
        access(1'b0, 2'd1, 1'b1, '0);
        chk(o_trap, "R5 read-vm traps read", {31'd0, o_trap}, 1);
        access(1'b1, 2'd1, 1'b1, 32'h1111_0004);
        chk(o_done, "R5 read-vm passes write", {31'd0, o_done}, 1);
        hyp_trap_rd_vm = 1'b0; hyp_trap_wr_vm = 1'b1;
        access(1'b0, 2'd1, 1'b1, '0);
        chk(o_done && o_rdata == 32'h1111_0004, "R5 write-vm passes read", o_rdata, 32'h1111_0004);
        access(1'b1, 2'd1, 1'b1, 32'h2222_0005);
        chk(o_trap, "R5 write-vm traps write", {31'd0, o_trap}, 1);
        hyp_trap_wr_vm = 1'b0;
        expect_copy(1'b1, 32'h1111_0004, "R5 trapped write dropped");
    endtask

    task automatic t_decode;
        req_crm = 4'b0001;
        access(1'b1, 2'd3, 1'b1, 32'h3333_0006);
        chk(!o_done && !o_undef && !o_trap, "R2 other encoding silent", {31'd0, o_done}, 0);
        req_crm = 4'b0000; req_opc2 = 3'b010;
        access(1'b1, 2'd3, 1'b1, 32'h3333_0007);
        chk(!o_done, "R2 opc2 mismatch silent", {31'd0, o_done}, 0);
        req_opc2 = 3'b000;
        expect_copy(1'b1, 32'h1111_0004, "R2 copy unchanged");
    endtask

    task automatic t_alias;
        @(negedge clk);
        alias_wr_en = 1'b1; alias_wr_data = 32'h4444_0008;
        @(negedge clk);
        alias_wr_en = 1'b0;
        chk(alias_rd_data == 32'h4444_0008, "R8 alias read", alias_rd_data, 32'h4444_0008);
        expect_copy(1'b0, 32'h4444_0008, "R8 alias hits secure");
        feat_aa64 = 1'b1;
        @(negedge clk);
        chk(alias_rd_data == 0, "R8 alias absent reads zero", alias_rd_data, 0);
        alias_wr_en = 1'b1; alias_wr_data = 32'h5555_0009;
        @(negedge clk);
        alias_wr_en = 1'b0;
        feat_aa64 = 1'b0;
        expect_copy(1'b0, 32'h4444_0008, "R8 alias write ignored");
    endtask

    task automatic t_capture;
        cap_valid = 1'b1; cap_addr = 32'h6666_000A;
        access(1'b1, 2'd3, 1'b0, 32'h7777_000B);
        expect_copy(1'b0, 32'h6666_000A, "R9 capture beats write");
        l3_aa32 = 1'b0;
        @(negedge clk);
        cap_valid = 1'b1; cap_addr = 32'h8888_000C; sec_ns = 1'b0;
        @(negedge clk);
        cap_valid = 1'b0; l3_aa32 = 1'b1;
        expect_copy(1'b1, 32'h8888_000C, "R9 unbanked capture to nonsecure");
        expect_copy(1'b0, 32'h6666_000A, "R9 secure untouched");
    endtask

    task automatic t_pulse;
        cap_valid = 1'b1; cap_addr = 32'h9999_000D;
        access(1'b0, 2'd3, 1'b1, '0);
        chk(o_rdata == 32'h8888_000C, "R10 read returns old value", o_rdata, 32'h8888_000C);
        @(negedge clk);
        chk(!rsp_done && !rsp_undef && !rsp_trap, "R10 pulse drops", {31'd0, rsp_done}, 0);
        expect_copy(1'b1, 32'h9999_000D, "R9 capture landed");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_level3_bank();
                t_low_levels();
                t_undef();
                t_crn6();
                t_vm();
                t_decode();
                t_alias();
                t_capture();
                t_pulse();
            end
            begin
                repeat (5000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule